// File: doc/BRIEF.md
# Processor Control Opcode Executor

This block carries out the one-byte machine-control operations of a 16-bit core. A decoded opcode byte arrives on a valid/ready input. The block then updates its carry, direction and interrupt-enable flags and spends a fixed number of clock cycles on each opcode. It signals the end of each opcode with a one-cycle `done` pulse. Two opcodes stall the block. The halt opcode parks it until an enabled interrupt request arrives. The wait opcode holds it until an active-low test pin is sampled low. A lock prefix raises a bus-lock output that covers the next opcode.

Back-pressure rules: `op_ready` is high only while the block is idle. An opcode is taken on a rising edge where `op_valid` and `op_ready` are both high. While `op_ready` is low, the producer must hold its byte, and the block takes no action on it. `op_ready` comes back in the same cycle as `done`, so opcodes can follow one another with no gap.

Top module: `pctl_exec`

## Requirements
- R1: After reset the three flags are 0, `busy`, `done`, `bus_lock` and `halted` are 0, and `op_ready` is 1.
- R2: Byte 0xF9 sets the carry flag, 0xF8 clears it and 0xF5 inverts it.
- R3: Byte 0xFD sets the direction flag and 0xFC clears it. Byte 0xFB sets the interrupt-enable flag and 0xFA clears it.
- R4: Bytes 0xF8, 0xF5, 0xF9, 0xFC, 0xFD, 0xFA, 0xFB, 0xF4 and 0xF0 keep `busy` high for exactly 2 cycles after acceptance. `done` follows in the next cycle, and the flags change only in a cycle where `done` is high.
- R5: Byte 0x90 is busy for 3 cycles and changes no flag. Any byte not listed in R2 to R8 is busy for 2 cycles and changes no flag.
- R6: Byte 0x9B first samples `test_n` once per cycle and stalls while it is high. After the edge that sees it low, the block is busy for 6 more cycles before `done`. With `test_n` already low, the total busy time is 7 cycles.
- R7: Byte 0xF4 raises `halted` together with its `done` and keeps `busy` high. A high `irq` ends the halt at the next edge only while the interrupt-enable flag is 1. Otherwise the block stays halted until reset.
- R8: Byte 0xF0 raises `bus_lock` together with its `done`. `bus_lock` stays high through the next opcode and falls in the cycle after that opcode's `done`.
- R9: `op_ready` is high only when the block is idle. A byte offered while `op_ready` is low is not taken and changes no flag.
- R10: `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode byte is offered |
| op_byte | input | 8 | Decoded opcode byte |
| op_ready | output | 1 | Block is idle and takes the offered byte |
| test_n | input | 1 | Active-low release for the wait opcode |
| irq | input | 1 | Interrupt request that ends a halt |
| busy | output | 1 | An opcode is executing, stalled or halted |
| done | output | 1 | One-cycle pulse at the end of an opcode |
| carry_flag | output | 1 | Carry flag |
| dir_flag | output | 1 | Direction flag |
| int_en | output | 1 | Interrupt-enable flag |
| bus_lock | output | 1 | Bus lock held for the opcode after a lock prefix |
| halted | output | 1 | Block is in the halt state |

## Verification
The release of `bus_lock` at the end of the locked opcode can fall in the same cycle as the acceptance of the next opcode. This happens because `op_ready` returns in the cycle where `done` is high. The bench provokes this by issuing lock, then carry-invert, then clear-direction with no gap between them. It judges the result by requiring `bus_lock` high in every busy cycle of the second opcode and low in every busy cycle of the third.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

  typedef enum logic [3:0] {
    K_CARRY_CLR, K_CARRY_INV, K_CARRY_SET,
    K_DIR_CLR,   K_DIR_SET,
    K_IE_CLR,    K_IE_SET,
    K_HALT,      K_TESTWAIT,  K_LOCKPFX,
    K_IDLEOP,    K_OTHER
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_EXEC, ST_TEST, ST_HALT
  } exec_state_e;

  localparam logic [7:0] BYTE_CARRY_CLR = 8'hF8;
  localparam logic [7:0] BYTE_CARRY_INV = 8'hF5;
  localparam logic [7:0] BYTE_CARRY_SET = 8'hF9;
  localparam logic [7:0] BYTE_DIR_CLR   = 8'hFC;
  localparam logic [7:0] BYTE_DIR_SET   = 8'hFD;
  localparam logic [7:0] BYTE_IE_CLR    = 8'hFA;
  localparam logic [7:0] BYTE_IE_SET    = 8'hFB;
  localparam logic [7:0] BYTE_HALT      = 8'hF4;
  localparam logic [7:0] BYTE_TESTWAIT  = 8'h9B;
  localparam logic [7:0] BYTE_LOCKPFX   = 8'hF0;
  localparam logic [7:0] BYTE_IDLEOP    = 8'h90;

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
  import pctl_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SHORT_CYC = 2,
  parameter int NOP_CYC   = 3
) (
  input  logic [7:0]       byte_i,
  output op_kind_e         kind_o,
  output logic [CNT_W-1:0] load_o
);

  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] NOP_LOAD   = CNT_W'(NOP_CYC - 1);

  always_comb begin
    unique case (byte_i)
      BYTE_CARRY_CLR: kind_o = K_CARRY_CLR;
      BYTE_CARRY_INV: kind_o = K_CARRY_INV;
      BYTE_CARRY_SET: kind_o = K_CARRY_SET;
      BYTE_DIR_CLR:   kind_o = K_DIR_CLR;
      BYTE_DIR_SET:   kind_o = K_DIR_SET;
      BYTE_IE_CLR:    kind_o = K_IE_CLR;
      BYTE_IE_SET:    kind_o = K_IE_SET;
      BYTE_HALT:      kind_o = K_HALT;
      BYTE_TESTWAIT:  kind_o = K_TESTWAIT;
      BYTE_LOCKPFX:   kind_o = K_LOCKPFX;
      BYTE_IDLEOP:    kind_o = K_IDLEOP;
      default:        kind_o = K_OTHER;
    endcase
  end

  // The wait opcode reloads its own count once the test pin releases it.
  assign load_o = (kind_o == K_IDLEOP) ? NOP_LOAD : SHORT_LOAD;

endmodule

// File: rtl/pctl_timer.sv
module pctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= value_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pctl_flags.sv
module pctl_flags
  import pctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     apply_i,
  input  op_kind_e kind_i,
  output logic     cf_o,
  output logic     df_o,
  output logic     ie_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_o <= 1'b0;
      df_o <= 1'b0;
      ie_o <= 1'b0;
    end else if (apply_i) begin
      case (kind_i)
        K_CARRY_CLR: cf_o <= 1'b0;
        K_CARRY_SET: cf_o <= 1'b1;
        K_CARRY_INV: cf_o <= ~cf_o;
        K_DIR_CLR:   df_o <= 1'b0;
        K_DIR_SET:   df_o <= 1'b1;
        K_IE_CLR:    ie_o <= 1'b0;
        K_IE_SET:    ie_o <= 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/pctl_exec.sv
module pctl_exec
  import pctl_pkg::*;
#(
  parameter int SHORT_CYC = 2,
  parameter int NOP_CYC   = 3,
  parameter int WAIT_CYC  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  output logic       op_ready,
  input  logic       test_n,
  input  logic       irq,
  output logic       busy,
  output logic       done,
  output logic       carry_flag,
  output logic       dir_flag,
  output logic       int_en,
  output logic       bus_lock,
  output logic       halted
);

  localparam int MAX_A   = (SHORT_CYC > NOP_CYC) ? SHORT_CYC : NOP_CYC;
  localparam int MAX_CYC = (MAX_A > WAIT_CYC) ? MAX_A : WAIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);

  exec_state_e      state_q;
  op_kind_e         cur_kind_q;
  op_kind_e         dec_kind;
  logic [CNT_W-1:0] dec_load;
  logic             accept;
  logic             test_seen;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_value;
  logic             tmr_zero;
  logic             finish;

  pctl_decode #(
    .CNT_W(CNT_W), .SHORT_CYC(SHORT_CYC), .NOP_CYC(NOP_CYC)
  ) u_decode (
    .byte_i(op_byte), .kind_o(dec_kind), .load_o(dec_load)
  );

  assign op_ready  = (state_q == ST_IDLE);
  assign accept    = op_valid && op_ready;
  assign test_seen = (state_q == ST_TEST) && !test_n;
  assign tmr_load  = accept || test_seen;
  assign tmr_value = test_seen ? WAIT_LOAD : dec_load;
  assign finish    = (state_q == ST_EXEC) && tmr_zero;

  pctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .value_i(tmr_value),
    .run_i(state_q == ST_EXEC), .zero_o(tmr_zero)
  );

  pctl_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .apply_i(finish), .kind_i(cur_kind_q),
    .cf_o(carry_flag), .df_o(dir_flag), .ie_o(int_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_kind_q <= K_IDLEOP;
      done       <= 1'b0;
      bus_lock   <= 1'b0;
    end else begin
      done <= finish;
      // release one cycle after the locked opcode reports done
      if (done && cur_kind_q != K_LOCKPFX) bus_lock <= 1'b0;
      if (finish && cur_kind_q == K_LOCKPFX) bus_lock <= 1'b1;
      case (state_q)
        ST_IDLE: if (accept) begin
          cur_kind_q <= dec_kind;
          state_q    <= (dec_kind == K_TESTWAIT) ? ST_TEST : ST_EXEC;
        end
        ST_TEST: if (!test_n) state_q <= ST_EXEC;
        ST_EXEC: if (tmr_zero) state_q <= (cur_kind_q == K_HALT) ? ST_HALT : ST_IDLE;
        ST_HALT: if (irq && int_en) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/pctl_exec_chk.sv
module pctl_exec_chk (
  input logic clk,
  input logic rst_n,
  input logic op_valid,
  input logic op_ready,
  input logic irq,
  input logic busy,
  input logic done,
  input logic carry_flag,
  input logic dir_flag,
  input logic int_en,
  input logic bus_lock,
  input logic halted
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);

  // R4
  flag_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({carry_flag, dir_flag, int_en}) |-> done);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !(irq && int_en)) |=> halted);

  // R7
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> done);

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> done);

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(done));

endmodule

bind pctl_exec pctl_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .irq(irq), .busy(busy), .done(done), .carry_flag(carry_flag),
  .dir_flag(dir_flag), .int_en(int_en), .bus_lock(bus_lock), .halted(halted)
);

// File: tb/tb_pctl_exec.sv
module tb_pctl_exec;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 13;

  // entry: {byte[14:7], cf, df, ie, busy cycles[3:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hF9, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 set carry
    {8'hF5, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 invert
    {8'hF5, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 invert
    {8'hF8, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 clear
    {8'hFD, 1'b0, 1'b1, 1'b0, 4'd2},  // R3 set dir
    {8'hFB, 1'b0, 1'b1, 1'b1, 4'd2},  // R3 set ie
    {8'h90, 1'b0, 1'b1, 1'b1, 4'd3},  // R5 no-op
    {8'h9B, 1'b0, 1'b1, 1'b1, 4'd7},  // R6 wait, test low
    {8'hFC, 1'b0, 1'b0, 1'b1, 4'd2},  // R3 clear dir
    {8'hF9, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    {8'hFA, 1'b1, 1'b0, 1'b0, 4'd2},  // R3 clear ie
    {8'h37, 1'b1, 1'b0, 1'b0, 4'd2},  // R5 unlisted byte
    {8'hFB, 1'b1, 1'b0, 1'b1, 4'd2}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic test_n = 1'b0, irq = 1'b0;
  logic op_ready, busy, done, carry_flag, dir_flag, int_en, bus_lock, halted;

  int checks = 0, fails = 0;

  pctl_exec dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_ready(op_ready), .test_n(test_n), .irq(irq), .busy(busy), .done(done),
    .carry_flag(carry_flag), .dir_flag(dir_flag), .int_en(int_en),
    .bus_lock(bus_lock), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string req);
    check({carry_flag, dir_flag, int_en} == 3'b000, req, {carry_flag, dir_flag, int_en}, 0);
    check({busy, done, bus_lock, halted, op_ready} == 5'b00001, req,
          {busy, done, bus_lock, halted, op_ready}, 1);
  endtask

  task automatic run_op(input logic [7:0] op, output int cyc, output bit lk_all, output bit lk_any);
    while (!op_ready) @(negedge clk);
    op_byte  = op;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 0; lk_all = 1'b1; lk_any = 1'b0;
    while (!done) begin
      cyc++;
      if (!bus_lock) lk_all = 1'b0;
      if (bus_lock)  lk_any = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    bit la, ly;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 reset");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][14:7], cyc, la, ly);
      check({carry_flag, dir_flag, int_en} == VEC[i][6:4], "R2/R3 flags",
            {carry_flag, dir_flag, int_en}, VEC[i][6:4]);
      check(cyc == int'(VEC[i][3:0]), "R4/R5/R6 busy cycles", cyc, VEC[i][3:0]);
    end

    // R6 wait stall, with R9 ignored offer while busy
    test_n   = 1'b1;
    op_byte  = 8'h9B;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(busy && !done, "R6 stall while test high", {busy, done}, 2);
    for (int k = 0; k < 3; k++) begin
      op_byte  = 8'hFA;
      op_valid = 1'b1;
      @(negedge clk);
      check(!op_ready, "R9 ready low while busy", op_ready, 0);
    end
    op_valid = 1'b0;
    test_n   = 1'b0;
    cyc = 0;
    @(negedge clk);
    while (!done) begin cyc++; @(negedge clk); end
    check(cyc == 6, "R6 cycles after release", cyc, 6);
    check(int_en == 1'b1, "R9 offered byte ignored", int_en, 1);
    check(done && op_ready, "R10 done with ready", {done, op_ready}, 3);
    @(negedge clk);
    check(!done, "R10 single pulse", done, 0);

    // R8 lock prefix, back-to-back opcodes
    run_op(8'hF0, cyc, la, ly);
    check(bus_lock == 1'b1, "R8 lock rises with done", bus_lock, 1);
    check(cyc == 2, "R4 lock cycles", cyc, 2);
    run_op(8'hF5, cyc, la, ly);
    check(la == 1'b1, "R8 lock held through next opcode", la, 1);
    check(carry_flag == 1'b0, "R2 invert under lock", carry_flag, 0);
    run_op(8'hFC, cyc, la, ly);
    check(ly == 1'b0, "R8 lock released after next done", ly, 0);

    // R7 halt with interrupts enabled
    run_op(8'hF4, cyc, la, ly);
    check(halted && busy && !op_ready, "R7 halted at done", {halted, busy, op_ready}, 6);
    check(cyc == 2, "R4 halt cycles", cyc, 2);
    repeat (3) @(negedge clk);
    check(halted == 1'b1, "R7 stays halted", halted, 1);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    check(!halted && op_ready, "R7 wake on irq", {halted, op_ready}, 1);

    // R7 halt with interrupts disabled
    run_op(8'hFA, cyc, la, ly);
    run_op(8'hF4, cyc, la, ly);
    irq = 1'b1;
    repeat (5) @(negedge clk);
    check(halted == 1'b1, "R7 irq ignored with ie clear", halted, 1);
    irq = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 reset leaves halt");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule